// File: doc/BRIEF.md
# Branch Trace Message Bus Generator

This block turns taken-branch events from a processor core into pairs of special bus cycles that external logic can capture for debug or profiling. The core presents an event on a valid strobe. The event carries the source and target instruction pointers, the source and target code segment selectors, the operating mode of the target and the default operand size of the target segment. While tracing is enabled, each taken branch becomes two handshaked bus cycles. The source cycle goes out first and the target cycle second. The mode and operand-size fields are packed into the upper address bits of the target cycle.

A small queue absorbs events that arrive while a pair is still on the bus. The queue slot stays occupied until the target cycle of its pair completes. When every slot is occupied the block raises a stall output. The core must hold its event until stall drops.

Top module: `btm_gen`

## Requirements
- R1: An event is taken into the queue only in a cycle where `br_valid`, `br_taken` and `trace_en` are all 1 and `stall` is 0. Any other event is ignored and produces no bus cycle.
- R2: Each accepted event produces exactly two bus cycles, a source cycle followed by a target cycle. Address bit 31 is 0 on the source cycle and 1 on the target cycle. Pairs go out in the order the events were accepted.
- R3: While a message cycle is active, `bus_be` is 8'hDF. When no message cycle is active, `bus_be`, `bus_addr` and `bus_data` are all 0. This includes the time during reset.
- R4: A cycle stays on the bus, with its outputs held, until `bus_ready` is sampled high. Sampling starts on the clock after the cycle's start cycle. `bus_ready` has no effect in the start cycle itself or while no cycle is active.
- R5: On the target cycle, address bits 30:29 carry the target mode: 00 for real, 10 for protected, 11 for virtual-8086. An input mode of 01 is sent as 00. Address bit 28 is 1 for a 32-bit target segment and 0 for a 16-bit one. On the source cycle, bits 30:28 are 0.
- R6: Address bits 27:20 and 3:0 are 0 on every cycle.
- R7: Address bits 19:4 carry the source selector on the source cycle and the target selector on the target cycle.
- R8: `bus_data` carries the source instruction pointer on the source cycle and the target instruction pointer on the target cycle.
- R9: The queue holds 4 events, and this count includes the pair currently on the bus. `stall` is 1 exactly when all 4 slots are occupied. No accepted event is lost.
- R10: `bus_start` is 1 for only the first clock of each cycle. Suppose an event is accepted at a clock edge while the block is idle with an empty queue. Its source cycle then starts in the cycle that follows the next edge. After a target handshake, the next queued source cycle starts in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Branch tracing enable |
| br_valid | input | 1 | Branch event strobe |
| br_taken | input | 1 | The branch was taken |
| src_ip | input | 32 | Source instruction pointer |
| tgt_ip | input | 32 | Target instruction pointer |
| src_sel | input | 16 | Source code segment selector |
| tgt_sel | input | 16 | Target code segment selector |
| tgt_mode | input | 2 | Target mode: 00 real, 10 protected, 11 virtual-8086 |
| tgt_op32 | input | 1 | Target default operand size is 32-bit |
| stall | output | 1 | Queue full, hold the event |
| bus_start | output | 1 | First clock of a message cycle |
| bus_addr | output | 32 | Message address bus |
| bus_data | output | 32 | Message data bus |
| bus_be | output | 8 | Byte enables |
| bus_ready | input | 1 | External logic ends the active cycle |

## Verification
The hardest state to reach from the ports is a full queue that receives a new event in the same cycle as a target handshake frees a slot. Reaching it needs a long run of ready held low while events keep arriving, followed by a release of ready. The bench produces it with a phase of dense events and rare ready, followed by a phase of back-to-back events with ready always high. A behavioural reference model with a queue predicts every output on every clock. The comparison therefore catches a slot that is freed early, a pair that is split, and a mode value of 01 that leaks out onto the bus.

// File: rtl/btm_pkg.sv
package btm_pkg;

    typedef enum logic [1:0] {
        MODE_REAL = 2'b00,
        MODE_PROT = 2'b10,
        MODE_V86  = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SRC  = 2'd1,
        PH_TGT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [31:0] src_ip;
        logic [31:0] tgt_ip;
        logic [15:0] src_sel;
        logic [15:0] tgt_sel;
        tmode_e      mode;
        logic        op32;
    } brev_t;

    localparam int unsigned EVT_W  = $bits(brev_t);
    localparam logic [7:0]  MSG_BE = 8'hDF;

    // R5: the reserved code 01 is never sent; it becomes real mode
    function automatic tmode_e norm_mode(input logic [1:0] m);
        case (m)
            2'b10:   return MODE_PROT;
            2'b11:   return MODE_V86;
            default: return MODE_REAL;
        endcase
    endfunction

    // R2 R5 R6 R7: address packing for one message cycle
    function automatic logic [31:0] msg_addr(input logic is_tgt,
                                             input logic [15:0] sel,
                                             input tmode_e m,
                                             input logic op32);
        logic [31:0] a;
        a        = '0;
        a[31]    = is_tgt;
        a[19:4]  = sel;
        if (is_tgt) begin
            a[30:29] = m;
            a[28]    = op32;
        end
        return a;
    endfunction

endpackage

// File: rtl/btm_fifo.sv
module btm_fifo
    import btm_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  brev_t       din,
    input  logic        pop,
    output brev_t       dout,
    output logic        full,
    output logic        empty,
    output logic        last
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    brev_t         mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign last  = (count == CW'(1));
    assign dout  = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= din;
                wptr      <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            end
            if (pop) begin
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

endmodule

// File: rtl/btm_seq.sv
module btm_seq
    import btm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   have_evt,
    input  logic   last_evt,
    input  logic   ready,
    output phase_e phase,
    output logic   start,
    output logic   pop
);
    logic first;
    logic done;

    // R4: ready counts only after the start cycle
    assign done  = (phase != PH_IDLE) && !first && ready;
    assign start = (phase != PH_IDLE) && first;
    assign pop   = (phase == PH_TGT) && done;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            first <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (have_evt) begin
                        phase <= PH_SRC;
                        first <= 1'b1;
                    end
                end
                PH_SRC: begin
                    if (done) begin
                        phase <= PH_TGT;
                        first <= 1'b1;
                    end else begin
                        first <= 1'b0;
                    end
                end
                PH_TGT: begin
                    if (done) begin
                        phase <= last_evt ? PH_IDLE : PH_SRC;
                        first <= !last_evt;
                    end else begin
                        first <= 1'b0;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    first <= 1'b0;
                end
            endcase
        end
    end

    // R4
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !start && !ready) |=> $stable(phase));

    // R10
    single_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

endmodule

// File: rtl/btm_pack.sv
module btm_pack
    import btm_pkg::*;
(
    input  phase_e      phase,
    input  brev_t       ev,
    output logic [31:0] addr,
    output logic [31:0] data,
    output logic [7:0]  be
);
    always_comb begin
        addr = '0;
        data = '0;
        be   = '0;
        case (phase)
            PH_SRC: begin
                addr = msg_addr(1'b0, ev.src_sel, ev.mode, ev.op32);
                data = ev.src_ip;
                be   = MSG_BE;
            end
            PH_TGT: begin
                addr = msg_addr(1'b1, ev.tgt_sel, ev.mode, ev.op32);
                data = ev.tgt_ip;
                be   = MSG_BE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/btm_gen.sv
module btm_gen
    import btm_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trace_en,
    input  logic        br_valid,
    input  logic        br_taken,
    input  logic [31:0] src_ip,
    input  logic [31:0] tgt_ip,
    input  logic [15:0] src_sel,
    input  logic [15:0] tgt_sel,
    input  logic [1:0]  tgt_mode,
    input  logic        tgt_op32,
    output logic        stall,
    output logic        bus_start,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_data,
    output logic [7:0]  bus_be,
    input  logic        bus_ready
);
    brev_t  in_ev, head;
    phase_e phase;
    logic   push, pop, full, empty, last;

    // R1: only taken branches while tracing, and only with room
    assign push = br_valid && br_taken && trace_en && !full;
    assign stall = full;

    always_comb begin
        in_ev.src_ip  = src_ip;
        in_ev.tgt_ip  = tgt_ip;
        in_ev.src_sel = src_sel;
        in_ev.tgt_sel = tgt_sel;
        in_ev.mode    = norm_mode(tgt_mode);
        in_ev.op32    = tgt_op32;
    end

    btm_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (in_ev),
        .pop   (pop),
        .dout  (head),
        .full  (full),
        .empty (empty),
        .last  (last)
    );

    btm_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .have_evt (!empty),
        .last_evt (last),
        .ready    (bus_ready),
        .phase    (phase),
        .start    (bus_start),
        .pop      (pop)
    );

    btm_pack u_pack (
        .phase (phase),
        .ev    (head),
        .addr  (bus_addr),
        .data  (bus_data),
        .be    (bus_be)
    );

    // R2
    src_before_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_start && bus_addr[31]) |-> $past(phase) == PH_SRC);

    // R3
    be_value_chk: assert property (@(posedge clk) disable iff (rst)
        bus_start |-> bus_be == MSG_BE);

    // R5
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_be != 8'h00 && bus_addr[31]) |-> bus_addr[30:29] != 2'b01);

    // R6
    zero_field_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr[27:20] == 8'h00 && bus_addr[3:0] == 4'h0);

endmodule

// File: tb/btm_gen_tb.sv
`timescale 1ns/1ps
module btm_gen_tb;

    typedef struct {
        logic [31:0] sip;
        logic [31:0] tip;
        logic [15:0] ss;
        logic [15:0] ts;
        logic [1:0]  md;
        logic        op;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trace_en = 1'b0, br_valid = 1'b0, br_taken = 1'b0;
    logic [31:0] src_ip = '0, tgt_ip = '0;
    logic [15:0] src_sel = '0, tgt_sel = '0;
    logic [1:0]  tgt_mode = '0;
    logic        tgt_op32 = 1'b0;
    logic        bus_ready = 1'b0;
    logic        stall, bus_start;
    logic [31:0] bus_addr, bus_data;
    logic [7:0]  bus_be;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    ev_t q[$];
    int  ph = 0;      // 0 idle, 1 source, 2 target
    bit  fresh = 0;

    always #4 clk = ~clk;

    btm_gen u_dut (
        .clk(clk), .rst(rst), .trace_en(trace_en), .br_valid(br_valid),
        .br_taken(br_taken), .src_ip(src_ip), .tgt_ip(tgt_ip),
        .src_sel(src_sel), .tgt_sel(tgt_sel), .tgt_mode(tgt_mode),
        .tgt_op32(tgt_op32), .stall(stall), .bus_start(bus_start),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be),
        .bus_ready(bus_ready)
    );

    // Reference model
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            ph = 0;
            fresh = 0;
        end else begin
            bit acc;
            ev_t e;
            acc = br_valid && br_taken && trace_en && (q.size() < 4);
            if (ph == 1 && !fresh && bus_ready) begin
                ph = 2; fresh = 1;
            end else if (ph == 2 && !fresh && bus_ready) begin
                void'(q.pop_front());
                if (q.size() > 0) begin ph = 1; fresh = 1; end
                else begin ph = 0; fresh = 0; end
            end else if (ph == 0 && q.size() > 0) begin
                ph = 1; fresh = 1;
            end else begin
                fresh = 0;
            end
            if (acc) begin
                e.sip = src_ip; e.tip = tgt_ip; e.ss = src_sel; e.ts = tgt_sel;
                e.md = (tgt_mode == 2'b01) ? 2'b00 : tgt_mode;
                e.op = tgt_op32;
                q.push_back(e);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] ea, ed;
        logic [7:0]  eb;
        ea = '0; ed = '0; eb = '0;
        if (ph != 0) begin
            eb = 8'hDF;
            if (ph == 1) begin
                ea[19:4] = q[0].ss; ed = q[0].sip;
            end else begin
                ea[31] = 1'b1; ea[30:29] = q[0].md; ea[28] = q[0].op;
                ea[19:4] = q[0].ts; ed = q[0].tip;
            end
        end
        chk("R1 R4 R10 start", {31'd0, bus_start}, {31'd0, (ph != 0) && fresh});
        chk("R9 stall", {31'd0, stall}, {31'd0, q.size() == 4});
        chk("R3 be", {24'd0, bus_be}, {24'd0, eb});
        chk("R2 a31", {31'd0, bus_addr[31]}, {31'd0, ea[31]});
        chk("R5 mode/size", {29'd0, bus_addr[30:28]}, {29'd0, ea[30:28]});
        chk("R6 zero bits", {20'd0, bus_addr[27:20], bus_addr[3:0]}, 32'd0);
        chk("R7 selector", {16'd0, bus_addr[19:4]}, {16'd0, ea[19:4]});
        chk("R8 data", bus_data, ed);
    endtask

    task automatic drive(input int vp, input int rp, input int enp, input int tkp);
        trace_en  = ($urandom_range(99) < enp);
        br_valid  = ($urandom_range(99) < vp);
        br_taken  = ($urandom_range(99) < tkp);
        src_ip    = $urandom; tgt_ip = $urandom;
        src_sel   = 16'($urandom); tgt_sel = 16'($urandom);
        tgt_mode  = 2'($urandom);
        tgt_op32  = 1'($urandom);
        bus_ready = ($urandom_range(99) < rp);
    endtask

    initial begin
        repeat (4) begin
            @(negedge clk);
            // R3: reset state, bus idle
            chk("R3 reset be", {24'd0, bus_be}, 32'd0);
            chk("R9 reset stall", {31'd0, stall}, 32'd0);
            chk("R10 reset start", {31'd0, bus_start}, 32'd0);
        end
        rst = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            compare();
            if (c < 500)       drive(30, 50, 100, 100);
            else if (c < 1000) drive(50, 60, 50, 50);    // R1 gating
            else if (c < 1500) drive(90, 10, 100, 100);  // R9 fill
            else if (c < 2000) drive(100, 100, 100, 100);// R10 back-to-back
            else if (c < 2300) drive(100, 70, 0, 100);   // R1 tracing off
            else if (c < 2600) drive(60, 30, 100, 100);  // R4 slow ready
            else               drive(0, 80, 100, 100);   // drain
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule